// File: doc/BRIEF.md
# Vector Doubleword Bit Permute Unit

This unit collects single bits from a 128-bit data vector under the control of a 128-bit index vector. The vector is treated as two doublewords, each handled on its own. In each doubleword, every one of the eight index bytes picks one bit out of the matching data doubleword. An index of 64 or more gives a zero. The eight picked bits are packed into one byte, and that byte is placed at the bottom of an otherwise zero 64-bit doubleword of the result.

All numbering is big-endian. Bit 0 of a doubleword is its most significant bit, byte 0 is its most significant byte, and doubleword 0 sits in vector bits 127:64. Operations arrive over a valid/ready handshake and leave through a one-deep result register. A vector-enable input is sampled with each accepted operation. If that enable is low, the operation does not produce a result. It returns an unavailable flag in its place and leaves the result register untouched.

Top module: `vdw_bitperm`

## Requirements
- R1: Doubleword i of the result (i = 0 for bits 127:64, i = 1 for bits 63:0) depends only on doubleword i of the data and index inputs.
- R2: An index byte with value k < 64 selects data doubleword bit k. Bit 0 is the most significant, so bit k is doubleword bit position 63-k in LSB numbering.
- R3: An index byte with value 64 to 255 produces a 0 result bit.
- R4: Index byte j (j = 0 is the most significant byte of the doubleword) drives result bit 7-j of that doubleword in LSB numbering, and result bits 63:8 of each doubleword are always zero.
- R5: An operation is accepted when in_valid and in_ready are both high. out_valid is high on the following cycle. in_ready equals (not out_valid) or out_ready.
- R6: While out_valid is high and out_ready is low, out_valid, out_result and out_unavail hold their values, and any new input is not accepted.
- R7: An operation accepted with vec_en low gives out_valid with out_unavail high for that single transaction, and leaves out_result at its previous value.
- R8: While rst_n is low on a clock edge, out_valid and out_unavail are cleared on that edge.
- R9: out_unavail is never high unless out_valid is high. An operation accepted with vec_en high gives out_unavail low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_data | input | 128 | Data vector, two doublewords |
| in_index | input | 128 | Index vector, one byte per result bit |
| vec_en | input | 1 | Vector facility enabled for this operation |
| out_valid | output | 1 | Result or exception present |
| out_ready | input | 1 | Consumer takes the output this cycle |
| out_result | output | 128 | Permuted result |
| out_unavail | output | 1 | Operation refused: vector facility disabled |

## Verification
Every result and every exception flag is due exactly one clock edge after the edge that accepts the operation. The bench drives inputs on the falling edge and samples on the next falling edge, so each check reads the register that the intervening rising edge loaded. During backpressure the bench samples on several falling edges in a row and expects the same values each time. After a refused operation it reads the result on the cycle due and compares it with the result of the operation before.

// File: rtl/vbp_pkg.sv
// Package: shared constants and helpers for the doubleword bit permute unit.
// Assumes big-endian bit numbering inside a doubleword (bit 0 = MSB).
package vbp_pkg;

    // Default geometry of the unit
    localparam int DEF_DW_W   = 64;
    localparam int DEF_NUM_DW = 2;
    localparam int DEF_SEL_W  = 8;

    // Lanes (result bits) per doubleword given doubleword and selector widths
    function automatic int lanes_per_dw(input int dw_w, input int sel_w);
        return dw_w / sel_w;
    endfunction

endpackage

// File: rtl/vbp_bit_pick.sv
// Module: vbp_bit_pick
// Picks one bit of a doubleword addressed by a big-endian index, where index 0
// is the most significant bit. An index at or beyond DW_W gives 0.
// Assumes DW_W is a power of two not wider than the selector can address.
module vbp_bit_pick #(
    parameter int DW_W  = 64,
    parameter int SEL_W = 8
) (
    input  logic [DW_W-1:0]  dw,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_o
);
    localparam int POS_W = $clog2(DW_W);

    logic             in_range;
    logic [POS_W-1:0] pos;

    // Range test: any selector value of DW_W or more is out of range
    always_comb begin
        in_range = ({{(32-SEL_W){1'b0}}, sel} < 32'(DW_W));
    end

    // Map the big-endian index to the LSB-numbered position and pick the bit
    always_comb begin
        pos   = POS_W'(DW_W - 1) - sel[POS_W-1:0];
        bit_o = in_range ? dw[pos] : 1'b0;
    end

endmodule

// File: rtl/vbp_dword_lane.sv
// Module: vbp_dword_lane
// Builds one doubleword of the result. Each selector byte picks one data bit.
// The packed byte has its first selector in the MSB, and it is zero-extended to DW_W.
// Assumes DW_W is a multiple of SEL_W.
module vbp_dword_lane
    import vbp_pkg::*;
#(
    parameter int DW_W  = DEF_DW_W,
    parameter int SEL_W = DEF_SEL_W
) (
    input  logic [DW_W-1:0] dw,
    input  logic [DW_W-1:0] idx,
    output logic [DW_W-1:0] result
);
    localparam int LANES = lanes_per_dw(DW_W, SEL_W);

    logic [LANES-1:0] perm;

    // One bit picker per selector byte; byte j feeds packed bit LANES-1-j
    for (genvar j = 0; j < LANES; j++) begin : g_pick
        vbp_bit_pick #(
            .DW_W (DW_W),
            .SEL_W(SEL_W)
        ) u_pick (
            .dw   (dw),
            .sel  (idx[DW_W-1-SEL_W*j -: SEL_W]),
            .bit_o(perm[LANES-1-j])
        );
    end

    // Zero-extend the packed byte into the low end of the doubleword
    always_comb begin
        result = DW_W'(perm);
    end

endmodule

// File: rtl/vbp_out_stage.sv
// Module: vbp_out_stage
// Single-entry output register with a valid/ready handshake on both sides.
// It captures the permuted vector when the facility is enabled. Otherwise it
// raises the unavailable flag and keeps the previous result.
// Assumes a synchronous active-low reset.
module vbp_out_stage #(
    parameter int VEC_W = 128,
    parameter int DW_W  = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             vec_en,
    input  logic [VEC_W-1:0] perm_vec,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_result,
    output logic             out_unavail
);
    localparam int NUM_DW = VEC_W / DW_W;

    logic fire;

    // Handshake: room when empty or when the current entry drains now
    always_comb begin
        in_ready = !out_valid || out_ready;
        fire     = in_valid && in_ready;
    end

    // Control flags: set on accept, clear on drain, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_unavail <= 1'b0;
        end else if (fire) begin
            out_valid   <= 1'b1;
            out_unavail <= !vec_en;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
            out_unavail <= 1'b0;
        end
    end

    // Result register: loaded only by an accepted, enabled operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
        end else if (fire && vec_en) begin
            out_result <= perm_vec;
        end
    end

    a_r5_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_unavail)));

    a_r7_refused_keeps_result: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !vec_en) |=> (out_unavail && $stable(out_result)));

    a_r9_unavail_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_unavail |-> out_valid);

    a_r9_enabled_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && vec_en) |=> !out_unavail);

    a_r8_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_unavail));

    // R4: upper bits of every doubleword of the held result stay zero
    for (genvar i = 0; i < NUM_DW; i++) begin : g_upper_chk
        a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_result[VEC_W-1-DW_W*i -: DW_W-8] == '0));
    end

endmodule

// File: rtl/vdw_bitperm.sv
// Module: vdw_bitperm (top)
// Doubleword bit permute unit. It has one lane per doubleword feeding a registered
// output stage. The latency is one cycle from acceptance to out_valid.
// Assumes big-endian numbering of bits, bytes and doublewords.
module vdw_bitperm
    import vbp_pkg::*;
#(
    parameter int DW_W   = DEF_DW_W,
    parameter int NUM_DW = DEF_NUM_DW,
    parameter int SEL_W  = DEF_SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [DW_W*NUM_DW-1:0] in_data,
    input  logic [DW_W*NUM_DW-1:0] in_index,
    input  logic                   vec_en,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [DW_W*NUM_DW-1:0] out_result,
    output logic                   out_unavail
);
    localparam int VEC_W = DW_W * NUM_DW;

    logic [VEC_W-1:0] perm_vec;

    // One independent lane per doubleword; doubleword 0 is the top slice
    for (genvar i = 0; i < NUM_DW; i++) begin : g_dw
        vbp_dword_lane #(
            .DW_W (DW_W),
            .SEL_W(SEL_W)
        ) u_lane (
            .dw    (in_data [VEC_W-1-DW_W*i -: DW_W]),
            .idx   (in_index[VEC_W-1-DW_W*i -: DW_W]),
            .result(perm_vec[VEC_W-1-DW_W*i -: DW_W])
        );
    end

    vbp_out_stage #(
        .VEC_W(VEC_W),
        .DW_W (DW_W)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .vec_en     (vec_en),
        .perm_vec   (perm_vec),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_result (out_result),
        .out_unavail(out_unavail)
    );

endmodule

// File: tb/vdw_bitperm_tb_top.sv
// Bench: sweeps every index value through every byte slot against an arithmetic
// model, then exercises backpressure, refused operations and reset.
module vdw_bitperm_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_data = '0;
    logic [127:0] in_index = '0;
    logic         vec_en = 1'b1;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_result;
    logic         out_unavail;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #4 clk = ~clk;

    vdw_bitperm dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_index(in_index), .vec_en(vec_en),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_unavail(out_unavail)
    );

    // Model from the requirements (R1..R4)
    function automatic logic [127:0] model(input logic [127:0] d, input logic [127:0] x);
        logic [127:0] r = '0;
        for (int i = 0; i < 2; i++) begin
            for (int j = 0; j < 8; j++) begin
                int b = int'(x[127-64*i-8*j -: 8]);
                if (b < 64) r[64*(1-i) + 7 - j] = d[127-64*i-b];
            end
        end
        return r;
    endfunction

    function automatic logic [63:0] next_rng(input logic [63:0] s);
        logic [63:0] t = s;
        t = t ^ (t << 13);
        t = t ^ (t >> 7);
        t = t ^ (t << 17);
        return t;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Issue one operation with out_ready high and check it one cycle later
    task automatic run_op(input logic [127:0] d, input logic [127:0] x, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_index = x; vec_en = 1'b1; out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && !out_unavail, "R5/R9 valid after accept",
              {126'b0, out_valid, out_unavail}, 128'h2);
        check(out_result == model(d, x), req, out_result, model(d, x));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin : main
        logic [127:0] d, x, prev, r0;
        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_unavail, "R8 reset state", {126'b0, out_valid, out_unavail}, 128'h0);
        check(in_ready, "R5 ready when empty", {127'b0, in_ready}, 128'h1);
        rst_n = 1'b1;

        // R2/R4: index 0 only in byte 0 of each doubleword, data MSB set
        run_op({64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
               {64'h00FF_FFFF_FFFF_FFFF, 64'h00FF_FFFF_FFFF_FFFF}, "R4 byte0 to bit7");
        check(out_result == {64'h80, 64'h80}, "R4 explicit 0x80", out_result, {64'h80, 64'h80});
        // R2: index 63 picks the LSB in every slot
        run_op({64'h1, 64'h0}, {64'h3F3F_3F3F_3F3F_3F3F, 64'h3F3F_3F3F_3F3F_3F3F}, "R2 index 63");
        check(out_result == {64'hFF, 64'h0}, "R2 explicit lsb", out_result, {64'hFF, 64'h0});
        // R3: all indices out of range with all-ones data
        run_op({128{1'b1}}, {16{8'h40}}, "R3 index 64");
        check(out_result == '0, "R3 explicit zero", out_result, '0);
        run_op({128{1'b1}}, {16{8'hFF}}, "R3 index 255");

        // R1..R4 sweep: every byte slot sees every index value, four data patterns
        for (int p = 0; p < 4; p++) begin
            for (int v = 0; v < 256; v++) begin
                rng = next_rng(rng); d[127:64] = rng;
                rng = next_rng(rng); d[63:0] = rng;
                for (int k = 0; k < 16; k++) x[127-8*k -: 8] = 8'(v + 29*k + 7*p);
                run_op(d, x, "R2/R3/R4 sweep");
            end
        end

        // R1: changing doubleword 1 leaves doubleword 0 unchanged
        d = {64'hDEAD_BEEF_0123_4567, 64'h0}; x = {64'h0011_2233_4455_6677, 64'h0};
        run_op(d, x, "R1 base");
        r0 = out_result;
        run_op({d[127:64], 64'hFFFF_FFFF_FFFF_FFFF}, {x[127:64], 64'h0001_0203_0405_0607}, "R1 other dw");
        check(out_result[127:64] == r0[127:64], "R1 dw0 unchanged", out_result, r0);

        // R6: stall with a new offer pending
        @(negedge clk);
        in_valid = 1'b1; in_data = {128{1'b1}}; in_index = '0; vec_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        prev = out_result;
        out_ready = 1'b0;
        in_data = '0; in_index = {16{8'h05}};
        for (int c = 0; c < 3; c++) begin
            @(posedge clk);
            @(negedge clk);
            check(out_valid && !in_ready, "R6 valid held, not ready", {126'b0, out_valid, in_ready}, 128'h2);
            check(out_result == prev, "R6 result stable", out_result, prev);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(!out_valid, "R6 drained, stalled offer ignored", {127'b0, out_valid}, 128'h0);

        // R7: refused operation keeps previous result
        run_op({64'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_F0F0_F0F0_F0F0}, {16{8'h04}}, "R7 setup");
        prev = out_result;
        @(negedge clk);
        in_valid = 1'b1; in_data = {128{1'b1}}; in_index = '0; vec_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; vec_en = 1'b1;
        check(out_valid && out_unavail, "R7 unavail flag", {126'b0, out_valid, out_unavail}, 128'h3);
        check(out_result == prev, "R7 result kept", out_result, prev);
        @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_unavail, "R9 flag single transaction", {126'b0, out_valid, out_unavail}, 128'h0);
        run_op({128{1'b1}}, '0, "R9 enabled after refusal");

        // R8: reset while a result is held
        @(negedge clk);
        in_valid = 1'b1; vec_en = 1'b0; out_ready = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; vec_en = 1'b1;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_unavail, "R8 reset clears held", {126'b0, out_valid, out_unavail}, 128'h0);
        rst_n = 1'b1; out_ready = 1'b1;

        finish_run();
    end

endmodule